// File: doc/BRIEF.md
# MDIO Management Frame Master

This block is the master side of a two-wire station management link. A request on a single-cycle interface names the frame family (the older short-address family or the extended family with its separate address cycle), the kind of access, a 5-bit port address, a 5-bit register or device field and 16 bits of write data. The block then serializes a complete 64-slot frame onto a divided management clock and a bidirectional data line, and reports completion with a one-cycle done pulse. It returns 16 bits of read data when the access is a read.

The management clock is derived from the system clock by an even divider parameter and has a 50% duty cycle. It stays low whenever no frame is in flight. The data line is exposed as separate output value, output enable and input signals, so the pad's tri-state buffer lives outside the block. Outgoing data only changes on the falling clock edge. Incoming read bits are captured on the rising clock edge.

Top module: `mdio_master`

## Requirements
- R1: Each accepted frame begins with 32 clock slots in which the master drives the data line high.
- R2: The two start bits following the preamble are 0,0 for the extended family (`clause45_i`=1) and 0,1 for the short family (`clause45_i`=0).
- R3: `kind_i` encodes 00 address, 01 write, 10 read. The two opcode bits sent are: extended address 00, extended write 01, extended read 11; short write 01, short read 10.
- R4: After the opcode, the 5-bit port address and then the 5-bit register/device field are sent, each most significant bit first.
- R5: Write and address frames drive the turnaround as 1 then 0, then the 16 bits of `wdata_i` most significant bit first, with the output enable high for all 64 slots.
- R6: Read frames drop the output enable from the first turnaround slot to the end of the frame. The last 16 slots are sampled from `mdio_i` at each rising clock edge, most significant bit first, and presented on `rdata_o` together with `done_o`.
- R7: `mdio_o` and `mdio_oe_o` never change while `mdc_o` is high.
- R8: `mdc_o` has a period of DIV system clocks, high for DIV/2 and low for DIV/2, and is low whenever `busy_o` is low.
- R9: `busy_o` is high for exactly 64*DIV cycles from the edge that accepts a request. `done_o` pulses for one cycle, in the first cycle after `busy_o` falls.
- R10: A request made while busy, a short-family address request, and `kind_i`=11 are all ignored. They start no frame, and they leave an in-flight frame unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Start-frame request, sampled when idle |
| clause45_i | input | 1 | 1 = extended frame family, 0 = short family |
| kind_i | input | 2 | Access kind: 00 address, 01 write, 10 read |
| port_addr_i | input | 5 | Port address field |
| reg_addr_i | input | 5 | Register or device field |
| wdata_i | input | 16 | Write data or extended address value |
| busy_o | output | 1 | Frame in flight |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 16 | Captured read data |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe_o | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input value |

## Verification
A bit counter that slips or a shift register that loses its alignment moves every later field. A single frame then shows a wrong start, opcode or data bit at the rising clock edge in the slot where the slip happened, and the busy window changes length by a multiple of DIV cycles. A wrong read-release decision shows up within one slot as an enabled driver in a turnaround or data slot. A phase counter error appears on the very first clock pulse as a high time other than DIV/2.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PRE_BITS   = 32;
  localparam int FRAME_BITS = 64;
  localparam int PA_W       = 5;
  localparam int RA_W       = 5;
  localparam int DATA_W     = 16;
  localparam int TA_SLOT    = 46;  // first turnaround slot
  localparam int CAP_SLOT   = 48;  // first read data slot

  localparam logic [1:0] KIND_ADDR  = 2'b00;
  localparam logic [1:0] KIND_WRITE = 2'b01;
  localparam logic [1:0] KIND_READ  = 2'b10;
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int DIV = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int HALF  = DIV / 2;
  localparam int CNT_W = (DIV > 2) ? $clog2(DIV) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic             mdc_q;

  assign rise_o = run_i && (cnt_q == CNT_W'(HALF - 1));
  assign fall_o = run_i && (cnt_q == CNT_W'(DIV - 1));
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= fall_o ? '0 : cnt_q + 1'b1;
      if (rise_o)      mdc_q <= 1'b1;
      else if (fall_o) mdc_q <= 1'b0;
    end
  end

  assert_half_high_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> mdc_q);
endmodule

// File: rtl/mdio_frame_fmt.sv
module mdio_frame_fmt
  import mdio_pkg::*;
(
  input  logic              clause45_i,
  input  logic [1:0]        kind_i,
  input  logic [PA_W-1:0]   port_addr_i,
  input  logic [RA_W-1:0]   reg_addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              legal_o,
  output logic              is_read_o,
  output logic [FRAME_BITS-1:0] frame_o
);
  logic [1:0] st, op;

  always_comb begin
    st = clause45_i ? 2'b00 : 2'b01;
    unique case (kind_i)
      KIND_ADDR:  op = 2'b00;
      KIND_WRITE: op = 2'b01;
      KIND_READ:  op = clause45_i ? 2'b11 : 2'b10;
      default:    op = 2'b00;
    endcase
    legal_o   = (kind_i != 2'b11) && !(!clause45_i && kind_i == KIND_ADDR);
    is_read_o = (kind_i == KIND_READ);
    frame_o   = {{PRE_BITS{1'b1}}, st, op, port_addr_i, reg_addr_i, 2'b10, wdata_i};
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              clause45_i,
  input  logic [1:0]        kind_i,
  input  logic [PA_W-1:0]   port_addr_i,
  input  logic [RA_W-1:0]   reg_addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              mdc_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  input  logic              mdio_i
);
  localparam int SLOT_W = $clog2(FRAME_BITS);

  logic                  legal, is_read;
  logic [FRAME_BITS-1:0] frame;
  logic                  rise, fall;

  logic                  busy_q, rd_q, done_q, mdo_q, oe_q;
  logic [SLOT_W-1:0]     slot_q;
  logic [FRAME_BITS-1:0] sr_q;
  logic [DATA_W-1:0]     cap_q, rdata_q;

  mdio_frame_fmt u_fmt (
    .clause45_i (clause45_i),
    .kind_i     (kind_i),
    .port_addr_i(port_addr_i),
    .reg_addr_i (reg_addr_i),
    .wdata_i    (wdata_i),
    .legal_o    (legal),
    .is_read_o  (is_read),
    .frame_o    (frame)
  );

  mdio_clk_div #(.DIV(DIV)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (busy_q),
    .mdc_o (mdc_o),
    .rise_o(rise),
    .fall_o(fall)
  );

  wire accept = req_i && !busy_q && legal;
  wire last   = (slot_q == SLOT_W'(FRAME_BITS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      rd_q    <= 1'b0;
      done_q  <= 1'b0;
      mdo_q   <= 1'b1;
      oe_q    <= 1'b0;
      slot_q  <= '0;
      sr_q    <= '0;
      cap_q   <= '0;
      rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        rd_q   <= is_read;
        sr_q   <= frame;
        slot_q <= '0;
        mdo_q  <= frame[FRAME_BITS-1];
        oe_q   <= 1'b1;
      end else if (busy_q) begin
        if (rise && rd_q && slot_q >= SLOT_W'(CAP_SLOT))
          cap_q <= {cap_q[DATA_W-2:0], mdio_i};
        if (fall) begin
          if (last) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
            oe_q   <= 1'b0;
            mdo_q  <= 1'b1;
            if (rd_q) rdata_q <= cap_q;
          end else begin
            slot_q <= slot_q + 1'b1;
            sr_q   <= {sr_q[FRAME_BITS-2:0], 1'b0};
            mdo_q  <= sr_q[FRAME_BITS-2];
            // reads let go of the line from the first turnaround slot
            oe_q   <= !(rd_q && slot_q >= SLOT_W'(TA_SLOT - 1));
          end
        end
      end
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign rdata_o   = rdata_q;
  assign mdio_o    = mdo_q;
  assign mdio_oe_o = oe_q;

  assert_preamble_high_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && slot_q < SLOT_W'(PRE_BITS)) |-> (mdio_oe_o && mdio_o));

  assert_read_released_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && rd_q && slot_q >= SLOT_W'(TA_SLOT)) |-> !mdio_oe_o);

  assert_change_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mdc_o |=> (!mdc_o || ($stable(mdio_o) && $stable(mdio_oe_o))));

  assert_idle_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mdc_o);

  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)) ##1 !done_o);

  assert_ignore_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !(fall && last)) |=> ($stable(rd_q) && busy_q));
endmodule

// File: tb/mdio_master_test.sv
module mdio_master_test;
  localparam int DIV  = 4;
  localparam int HALF = DIV / 2;
  localparam time CLK_PERIOD = 10ns;

  logic        clk_i = 0, rst_ni = 0, req_i = 0, clause45_i = 0;
  logic [1:0]  kind_i = 0;
  logic [4:0]  port_addr_i = 0, reg_addr_i = 0;
  logic [15:0] wdata_i = 0;
  logic        busy_o, done_o, mdc_o, mdio_o, mdio_oe_o, mdio_i;
  logic [15:0] rdata_o;

  mdio_master #(.DIV(DIV)) uut (.*);

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0;
  logic [63:0] obs_d, obs_oe;
  int rises, busy_cyc, dones, hi_run, hi_bad, chg_hi;
  logic prev_mdc, prev_mdo, prev_oe;
  logic [15:0] phy_data;
  logic        phy_read;

  // PHY model: 0 on second turnaround slot, data in the last 16, pulled high otherwise
  assign mdio_i = !phy_read ? 1'b1 :
                  (rises == 47) ? 1'b0 :
                  (rises >= 48 && rises < 64) ? phy_data[63 - rises] : 1'b1;

  always @(negedge clk_i) begin
    if (busy_o) busy_cyc++;
    if (done_o) dones++;
    if (mdc_o && prev_mdc && (mdio_o !== prev_mdo || mdio_oe_o !== prev_oe)) chg_hi++;
    if (mdc_o && !prev_mdc && rises < 64) begin
      obs_d[63 - rises]  = mdio_o;
      obs_oe[63 - rises] = mdio_oe_o;
      rises++;
    end
    if (mdc_o) hi_run++;
    else begin
      if (prev_mdc && hi_run != HALF) hi_bad++;
      hi_run = 0;
    end
    prev_mdc = mdc_o; prev_mdo = mdio_o; prev_oe = mdio_oe_o;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  task automatic run_frame(input bit c45, input logic [1:0] kind, input logic [4:0] pa,
                           input logic [4:0] ra, input logic [15:0] wd, input logic [15:0] pd,
                           input bit poke);
    bit legal, rd;
    logic [1:0] st, op;
    logic [63:0] exp, exp_oe;
    legal = (kind != 2'b11) && !(!c45 && kind == 2'b00);
    rd    = (kind == 2'b10);
    st    = c45 ? 2'b00 : 2'b01;
    op    = (kind == 2'b00) ? 2'b00 : (kind == 2'b01) ? 2'b01 : (c45 ? 2'b11 : 2'b10);
    exp   = {32'hFFFF_FFFF, st, op, pa, ra, 2'b10, wd};
    exp_oe = rd ? {46'h3FFF_FFFF_FFFF, 18'h0} : '1;
    @(negedge clk_i);
    rises = 0; busy_cyc = 0; dones = 0; hi_bad = 0; chg_hi = 0;
    obs_d = '0; obs_oe = '0; phy_data = pd; phy_read = rd;
    @(negedge clk_i);
    req_i = 1; clause45_i = c45; kind_i = kind; port_addr_i = pa; reg_addr_i = ra; wdata_i = wd;
    @(negedge clk_i);
    req_i = 0;
    if (!legal) begin
      repeat (3 * DIV) @(negedge clk_i);
      chk(!busy_o && rises == 0 && dones == 0, "R10 illegal request ignored",
          {busy_o, 31'(rises), 32'(dones)}, 64'h0);
      return;
    end
    if (poke) begin
      repeat (40 * DIV) @(negedge clk_i);
      req_i = 1; clause45_i = ~c45; kind_i = 2'b01; port_addr_i = ~pa; reg_addr_i = ~ra; wdata_i = ~wd;
      @(negedge clk_i);
      req_i = 0;
    end
    for (int i = 0; i < 100 * DIV && dones == 0; i++) @(negedge clk_i);
    repeat (2 * DIV) @(negedge clk_i);
    chk(obs_d[63:32] == 32'hFFFF_FFFF && obs_oe[63:32] == 32'hFFFF_FFFF, "R1 preamble",
        {obs_d[63:32], obs_oe[63:32]}, '1);
    chk(obs_d[31:30] == st, "R2 start code", 64'(obs_d[31:30]), 64'(st));
    chk(obs_d[29:28] == op, "R3 opcode", 64'(obs_d[29:28]), 64'(op));
    chk(obs_d[27:18] == {pa, ra}, "R4 address fields", 64'(obs_d[27:18]), 64'({pa, ra}));
    if (!rd)
      chk(obs_d[17:0] == exp[17:0], "R5 turnaround and data", 64'(obs_d[17:0]), 64'(exp[17:0]));
    else
      chk(rdata_o == pd, "R6 read data", 64'(rdata_o), 64'(pd));
    chk(obs_oe == exp_oe, rd ? "R6 output enable" : "R5 output enable", obs_oe, exp_oe);
    chk(chg_hi == 0, "R7 change while clock high", 64'(chg_hi), 64'h0);
    chk(hi_bad == 0 && rises == 64 && !mdc_o, "R8 clock shape",
        {32'(hi_bad), 32'(rises)}, {32'h0, 32'd64});
    chk(busy_cyc == 64 * DIV && dones == 1, poke ? "R10 request while busy" : "R9 busy window",
        {32'(busy_cyc), 32'(dones)}, {32'(64 * DIV), 32'd1});
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    phy_read = 0; phy_data = 0; prev_mdc = 0; prev_mdo = 1; prev_oe = 0; hi_run = 0;
    rises = 0; busy_cyc = 0; dones = 0; hi_bad = 0; chg_hi = 0;
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !done_o && !mdc_o && !mdio_oe_o, "R8 reset state",
        {busy_o, done_o, mdc_o, mdio_oe_o}, 64'h0);
    rst_ni = 1;
    @(negedge clk_i);
    for (int c = 0; c < 2; c++)
      for (int k = 0; k < 4; k++)
        for (int p = 0; p < 3; p++) begin
          logic [15:0] w, r;
          w = (p == 0) ? 16'h0000 : (p == 1) ? 16'hFFFF : 16'(16'hA55A ^ (k * 16'h1111) ^ (c << 3));
          r = (p == 0) ? 16'hFFFF : (p == 1) ? 16'h0001 : 16'(16'h8C31 + k * 7 + c);
          run_frame(c[0], k[1:0], 5'(p * 11 + k), 5'(31 - p * 5 - c), w, r, 1'b0);
        end
    run_frame(1'b0, 2'b10, 5'h1E, 5'h11, 16'h0000, 16'h55AA, 1'b1);
    run_frame(1'b1, 2'b01, 5'h00, 5'h1F, 16'h8001, 16'h0000, 1'b1);
    finish_run();
  end
endmodule